// File: doc/BRIEF.md
# Flash Base-Address Decoder with Backdoor Window

This block sits between two bus masters and a synchronous on-chip flash read/write port. The processor core reaches the flash through a programmable base-address register that carries a valid bit. Any other master, and every write from the core, must go through a fixed backdoor window. That window lies a constant offset of 0x0400_0000 above a peripheral base address, which arrives as a plain input. The block decodes each request and steers it to the flash port with the right latency. Requests it does not accept get an error response.

While reset is active the register loads its valid bit from the boot-configuration inputs and the security flag. The base field is cleared to 0x0 only when the valid bit comes up set. Otherwise the base field keeps whatever software last wrote. Outside reset, software rewrites the base field and the valid bit through a write port. The flash size is a parameter. Both windows compare only the address bits above the array index.

Top module: `flash_bar_decoder`

## Requirements
- R1: While `rst_n` is low the valid bit is loaded as set when `boot_rcon`=1 and `boot_mode`=3'b110, or when `boot_rcon`=1, `boot_mode`=3'b111 and `boot_sel`=2'b00. With any other pin combination, and `sec_flag`=0, it is loaded clear.
- R2: While `rst_n` is low, `sec_flag`=1 loads the valid bit as set, whatever the boot pins are.
- R3: When reset loads the valid bit set, the base field becomes 0. When reset loads it clear, the base field keeps its previous value.
- R4: Outside reset, a cycle with `bar_we`=1 stores `bar_wbase` and `bar_wvalid`. Both appear on `bar_rbase` and `bar_rvalid` from the next cycle on. `bar_we` is ignored during reset.
- R5: The base window matches when the valid bit is set and byte-address bits [31:LOG2_BYTES] equal the base field. The flash word index is byte-address bits [LOG2_BYTES-1:2].
- R6: A core read in the base window is a direct read. It drives `fl_rd` with the word index in the request cycle, and `core_rdy` rises one cycle later with `core_rdata` equal to `fl_rdata`.
- R7: The backdoor window matches when bits [31:LOG2_BYTES] equal those of `periph_base` + 0x0400_0000. A read there, from either master, gets its ready strobe three cycles after the request.
- R8: A backdoor write drives `fl_wr` with the index and write data two cycles after the request. The master's ready strobe follows one cycle after that.
- R9: A request from the second master, or a core write, that matches only the base window gets ready and error together one cycle later, and the flash port stays idle.
- R10: A request that matches neither window gets no response and causes no flash access. This includes a core read to a base window whose valid bit is clear.
- R11: When a direct core read arrives in the cycle in which a backdoor access uses the flash port, the backdoor access keeps the port. The core read is issued one cycle later, and its ready comes two cycles after the request.
- R12: When both masters present backdoor requests in the same cycle, the second master's request enters first. The core request enters one cycle later, and its ready comes four cycles after the request.
- R13: A core read that matches both windows is served as a direct read. A write to that address is served through the backdoor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; boot inputs are sampled while low |
| boot_rcon | input | 1 | Reset-configuration enable pin |
| boot_mode | input | 3 | Boot mode pins |
| boot_sel | input | 2 | Boot-select pins for master mode |
| sec_flag | input | 1 | Flash secured flag |
| periph_base | input | 32-LOG2_BYTES | Peripheral base address, bits [31:LOG2_BYTES] |
| bar_we | input | 1 | Base-register write strobe |
| bar_wbase | input | 32-LOG2_BYTES | New base field |
| bar_wvalid | input | 1 | New valid bit |
| bar_rbase | output | 32-LOG2_BYTES | Current base field |
| bar_rvalid | output | 1 | Current valid bit |
| core_req | input | 1 | Core request pulse |
| core_we | input | 1 | Core write |
| core_addr | input | 30 | Core byte address bits [31:2] |
| core_wdata | input | 32 | Core write data |
| core_rdy | output | 1 | Core completion strobe |
| core_err | output | 1 | Core error, with `core_rdy` |
| core_rdata | output | 32 | Core read data, valid with `core_rdy` |
| alt_req | input | 1 | Second-master request pulse |
| alt_we | input | 1 | Second-master write |
| alt_addr | input | 30 | Second-master byte address bits [31:2] |
| alt_wdata | input | 32 | Second-master write data |
| alt_rdy | output | 1 | Second-master completion strobe |
| alt_err | output | 1 | Second-master error, with `alt_rdy` |
| alt_rdata | output | 32 | Second-master read data |
| fl_rd | output | 1 | Flash read strobe |
| fl_wr | output | 1 | Flash write strobe |
| fl_addr | output | LOG2_BYTES-2 | Flash word index |
| fl_wdata | output | 32 | Flash write data |
| fl_rdata | input | 32 | Flash read data, valid the cycle after `fl_rd` |

## Verification
The flash port can be wanted by two paths in one cycle: a backdoor access leaving its two-stage delay, and a fresh direct core read. The bench provokes this by starting a second-master backdoor read and then, two cycles later, a direct core read. It judges the result from the ready cycle and data of each master. The backdoor entry can also be contested, by both masters targeting the backdoor in the same cycle. There the core's ready must come exactly one cycle later than the uncontested backdoor latency.

// File: rtl/flbar_pkg.sv
package flbar_pkg;

    // Decode outcome for one request
    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_DIRECT = 2'd1,
        ACC_BACK   = 2'd2,
        ACC_ERR    = 2'd3
    } acc_kind_e;

    localparam int unsigned N_MASTERS = 2;
    localparam int unsigned CORE_ID   = 0;
    localparam int unsigned ALT_ID    = 1;

endpackage

// File: rtl/flbar_reg.sv
module flbar_reg #(
    parameter int unsigned BW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          boot_rcon,
    input  logic [2:0]    boot_mode,
    input  logic [1:0]    boot_sel,
    input  logic          sec_flag,
    input  logic          wr_en,
    input  logic [BW-1:0] wr_base,
    input  logic          wr_valid,
    output logic [BW-1:0] base_o,
    output logic          valid_o
);

    typedef struct packed {
        logic [BW-1:0] base;
        logic          valid;
    } bar_t;

    bar_t st_d, st_q;
    logic boot_ok;

    always_comb begin
        boot_ok = (boot_rcon && ((boot_mode == 3'b110) ||
                                 ((boot_mode == 3'b111) && (boot_sel == 2'b00))))
                  || sec_flag;
        st_d = st_q;
        if (!rst_n) begin
            st_d.valid = boot_ok;
            if (boot_ok) begin
                st_d.base = '0;
            end
        end else if (wr_en) begin
            st_d.base  = wr_base;
            st_d.valid = wr_valid;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign base_o  = st_q.base;
    assign valid_o = st_q.valid;

    AST_SEC_FORCES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) && $past(sec_flag)) |-> valid_o); // R2

    AST_BOOT_INVALID_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) && !$past(boot_rcon) && !$past(sec_flag)) |-> !valid_o); // R1

    AST_BOOT_BASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) && valid_o) |-> (base_o == '0)); // R3

    AST_BAR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en)) |-> ($stable(base_o) && $stable(valid_o))); // R4

endmodule

// File: rtl/flbar_decode.sv
module flbar_decode
    import flbar_pkg::*;
#(
    parameter int unsigned LOG2_BYTES = 19,
    parameter bit          IS_CORE    = 1'b1,
    parameter logic [31:0] BD_OFFSET  = 32'h0400_0000
) (
    input  logic [31:2]            addr,
    input  logic                   we,
    input  logic [31:LOG2_BYTES]   bar_base,
    input  logic                   bar_valid,
    input  logic [31:LOG2_BYTES]   periph_base,
    output acc_kind_e              kind,
    output logic [LOG2_BYTES-3:0]  idx
);

    localparam int unsigned BW = 32 - LOG2_BYTES;
    localparam logic [BW-1:0] OFF_HI = BD_OFFSET[31:LOG2_BYTES];

    logic [BW-1:0] bd_hi;
    logic          base_hit;
    logic          bd_hit;

    always_comb begin
        bd_hi    = periph_base + OFF_HI;
        base_hit = bar_valid && (addr[31:LOG2_BYTES] == bar_base);
        bd_hit   = (addr[31:LOG2_BYTES] == bd_hi);
        idx      = addr[LOG2_BYTES-1:2];
        if (IS_CORE && !we && base_hit) begin
            kind = ACC_DIRECT;
        end else if (bd_hit) begin
            kind = ACC_BACK;
        end else if (base_hit) begin
            kind = ACC_ERR;
        end else begin
            kind = ACC_NONE;
        end
    end

endmodule

// File: rtl/flbar_sched.sv
module flbar_sched
    import flbar_pkg::*;
#(
    parameter int unsigned AW = 17
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_MASTERS-1:0]  req_i,
    input  logic [N_MASTERS-1:0]  we_i,
    input  acc_kind_e             kind_i [N_MASTERS],
    input  logic [AW-1:0]         idx_i  [N_MASTERS],
    input  logic [31:0]           wd_i   [N_MASTERS],
    output logic                  fl_rd,
    output logic                  fl_wr,
    output logic [AW-1:0]         fl_addr,
    output logic [31:0]           fl_wdata,
    input  logic [31:0]           fl_rdata,
    output logic [N_MASTERS-1:0]  rdy_o,
    output logic [N_MASTERS-1:0]  err_o,
    output logic [31:0]           rdata_o [N_MASTERS]
);

    typedef struct packed {
        logic          vld;
        logic          we;
        acc_kind_e     kind;
        logic [AW-1:0] idx;
        logic [31:0]   wd;
    } req_t;

    typedef struct packed {
        logic          vld;
        logic          who;
        logic          we;
        logic [AW-1:0] idx;
        logic [31:0]   wd;
    } lane_t;

    typedef struct packed {
        req_t                 pend;
        lane_t                bd1;
        lane_t                bd2;
        logic                 iss_vld;
        logic                 iss_who;
        logic                 iss_we;
        logic [N_MASTERS-1:0] errp;
    } st_t;

    st_t   st_d, st_q;
    req_t  cur_c, cur_m;
    logic  c_bd, m_bd, c_dir_go, c_taken;

    always_comb begin
        st_d = st_q;

        // core request: a held one takes precedence over the input pins
        if (st_q.pend.vld) begin
            cur_c = st_q.pend;
        end else begin
            cur_c.vld  = req_i[CORE_ID];
            cur_c.we   = we_i[CORE_ID];
            cur_c.kind = kind_i[CORE_ID];
            cur_c.idx  = idx_i[CORE_ID];
            cur_c.wd   = wd_i[CORE_ID];
        end
        cur_m.vld  = req_i[ALT_ID];
        cur_m.we   = we_i[ALT_ID];
        cur_m.kind = kind_i[ALT_ID];
        cur_m.idx  = idx_i[ALT_ID];
        cur_m.wd   = wd_i[ALT_ID];

        c_bd     = cur_c.vld && (cur_c.kind == ACC_BACK);
        m_bd     = cur_m.vld && (cur_m.kind == ACC_BACK);
        c_dir_go = cur_c.vld && (cur_c.kind == ACC_DIRECT) && !st_q.bd2.vld;

        // flash port: delayed backdoor access first, then a direct read
        fl_rd    = 1'b0;
        fl_wr    = 1'b0;
        fl_addr  = '0;
        fl_wdata = '0;
        st_d.iss_vld = 1'b0;
        st_d.iss_who = 1'b0;
        st_d.iss_we  = 1'b0;
        if (st_q.bd2.vld) begin
            fl_rd    = !st_q.bd2.we;
            fl_wr    = st_q.bd2.we;
            fl_addr  = st_q.bd2.idx;
            fl_wdata = st_q.bd2.wd;
            st_d.iss_vld = 1'b1;
            st_d.iss_who = st_q.bd2.who;
            st_d.iss_we  = st_q.bd2.we;
        end else if (c_dir_go) begin
            fl_rd    = 1'b1;
            fl_addr  = cur_c.idx;
            st_d.iss_vld = 1'b1;
            st_d.iss_who = 1'(CORE_ID);
            st_d.iss_we  = 1'b0;
        end

        // backdoor delay line, one entry per cycle, second master first
        st_d.bd2 = st_q.bd1;
        st_d.bd1 = '0;
        if (m_bd) begin
            st_d.bd1.vld = 1'b1;
            st_d.bd1.who = 1'(ALT_ID);
            st_d.bd1.we  = cur_m.we;
            st_d.bd1.idx = cur_m.idx;
            st_d.bd1.wd  = cur_m.wd;
        end else if (c_bd) begin
            st_d.bd1.vld = 1'b1;
            st_d.bd1.who = 1'(CORE_ID);
            st_d.bd1.we  = cur_c.we;
            st_d.bd1.idx = cur_c.idx;
            st_d.bd1.wd  = cur_c.wd;
        end

        c_taken = c_dir_go || (c_bd && !m_bd) ||
                  (cur_c.vld && ((cur_c.kind == ACC_ERR) || (cur_c.kind == ACC_NONE)));
        st_d.pend     = cur_c;
        st_d.pend.vld = cur_c.vld && !c_taken;

        st_d.errp[CORE_ID] = cur_c.vld && (cur_c.kind == ACC_ERR);
        st_d.errp[ALT_ID]  = cur_m.vld && (cur_m.kind == ACC_ERR);

        if (!rst_n) begin
            st_d.pend.vld = 1'b0;
            st_d.bd1.vld  = 1'b0;
            st_d.bd2.vld  = 1'b0;
            st_d.iss_vld  = 1'b0;
            st_d.errp     = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    for (genvar g = 0; g < N_MASTERS; g++) begin : g_rsp
        logic done;
        assign done       = st_q.iss_vld && (st_q.iss_who == 1'(g));
        assign rdy_o[g]   = done || st_q.errp[g];
        assign err_o[g]   = st_q.errp[g];
        assign rdata_o[g] = (done && !st_q.iss_we) ? fl_rdata : 32'h0;
    end

    AST_PORT_USE_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_rd || fl_wr) |=> (rdy_o != '0)); // R6

    AST_ERR_NO_FLASH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o[ALT_ID] || err_o[CORE_ID]) |-> !(st_q.iss_vld && err_o[st_q.iss_who])); // R9

endmodule

// File: rtl/flash_bar_decoder.sv
module flash_bar_decoder
    import flbar_pkg::*;
#(
    parameter int unsigned LOG2_BYTES = 19,
    parameter logic [31:0] BD_OFFSET  = 32'h0400_0000,
    localparam int unsigned BW = 32 - LOG2_BYTES,
    localparam int unsigned AW = LOG2_BYTES - 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          boot_rcon,
    input  logic [2:0]    boot_mode,
    input  logic [1:0]    boot_sel,
    input  logic          sec_flag,
    input  logic [BW-1:0] periph_base,
    input  logic          bar_we,
    input  logic [BW-1:0] bar_wbase,
    input  logic          bar_wvalid,
    output logic [BW-1:0] bar_rbase,
    output logic          bar_rvalid,
    input  logic          core_req,
    input  logic          core_we,
    input  logic [29:0]   core_addr,
    input  logic [31:0]   core_wdata,
    output logic          core_rdy,
    output logic          core_err,
    output logic [31:0]   core_rdata,
    input  logic          alt_req,
    input  logic          alt_we,
    input  logic [29:0]   alt_addr,
    input  logic [31:0]   alt_wdata,
    output logic          alt_rdy,
    output logic          alt_err,
    output logic [31:0]   alt_rdata,
    output logic          fl_rd,
    output logic          fl_wr,
    output logic [AW-1:0] fl_addr,
    output logic [31:0]   fl_wdata,
    input  logic [31:0]   fl_rdata
);

    logic [BW-1:0]        base_q;
    logic                 valid_q;
    logic [29:0]          m_addr [N_MASTERS];
    logic [N_MASTERS-1:0] m_req, m_we, m_rdy, m_err;
    logic [31:0]          m_wd    [N_MASTERS];
    logic [31:0]          m_rdata [N_MASTERS];
    acc_kind_e            m_kind  [N_MASTERS];
    logic [AW-1:0]        m_idx   [N_MASTERS];

    flbar_reg #(.BW(BW)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .boot_rcon(boot_rcon),
        .boot_mode(boot_mode),
        .boot_sel (boot_sel),
        .sec_flag (sec_flag),
        .wr_en    (bar_we),
        .wr_base  (bar_wbase),
        .wr_valid (bar_wvalid),
        .base_o   (base_q),
        .valid_o  (valid_q)
    );

    assign bar_rbase  = base_q;
    assign bar_rvalid = valid_q;

    assign m_addr[CORE_ID] = core_addr;
    assign m_addr[ALT_ID]  = alt_addr;
    assign m_wd[CORE_ID]   = core_wdata;
    assign m_wd[ALT_ID]    = alt_wdata;
    assign m_req = {alt_req, core_req};
    assign m_we  = {alt_we, core_we};

    for (genvar g = 0; g < N_MASTERS; g++) begin : g_dec
        flbar_decode #(
            .LOG2_BYTES(LOG2_BYTES),
            .IS_CORE   (g == CORE_ID),
            .BD_OFFSET (BD_OFFSET)
        ) u_dec (
            .addr       (m_addr[g]),
            .we         (m_we[g]),
            .bar_base   (base_q),
            .bar_valid  (valid_q),
            .periph_base(periph_base),
            .kind       (m_kind[g]),
            .idx        (m_idx[g])
        );
    end

    flbar_sched #(.AW(AW)) u_sched (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (m_req),
        .we_i    (m_we),
        .kind_i  (m_kind),
        .idx_i   (m_idx),
        .wd_i    (m_wd),
        .fl_rd   (fl_rd),
        .fl_wr   (fl_wr),
        .fl_addr (fl_addr),
        .fl_wdata(fl_wdata),
        .fl_rdata(fl_rdata),
        .rdy_o   (m_rdy),
        .err_o   (m_err),
        .rdata_o (m_rdata)
    );

    assign core_rdy   = m_rdy[CORE_ID];
    assign core_err   = m_err[CORE_ID];
    assign core_rdata = m_rdata[CORE_ID];
    assign alt_rdy    = m_rdy[ALT_ID];
    assign alt_err    = m_err[ALT_ID];
    assign alt_rdata  = m_rdata[ALT_ID];

    AST_ALT_BD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_rdy && !alt_err) |-> $past(alt_req, 3)); // R7

    AST_ALT_ERR_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        alt_err |-> $past(alt_req)); // R9

    AST_CORE_ERR_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        core_err |-> ($past(core_req) && $past(core_we))); // R9

    AST_ONE_FLASH_OP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fl_rd, fl_wr})); // R8

endmodule

// File: tb/test_flash_bar_decoder.sv
module test_flash_bar_decoder;

    localparam int unsigned LOG2_BYTES = 19;
    localparam int unsigned BW = 32 - LOG2_BYTES;
    localparam int unsigned AW = LOG2_BYTES - 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          boot_rcon = 1'b1;
    logic [2:0]    boot_mode = 3'b110;
    logic [1:0]    boot_sel = 2'b00;
    logic          sec_flag = 1'b0;
    logic [31:0]   pbase = 32'h4000_0000;
    logic          bar_we = 1'b0;
    logic [31:0]   bar_wfull = 32'h0;
    logic          bar_wvalid = 1'b0;
    logic [BW-1:0] bar_rbase;
    logic          bar_rvalid;
    logic          core_req = 1'b0, core_we = 1'b0;
    logic [31:0]   core_a = 32'h0, core_wdata = 32'h0;
    logic          core_rdy, core_err;
    logic [31:0]   core_rdata;
    logic          alt_req = 1'b0, alt_we = 1'b0;
    logic [31:0]   alt_a = 32'h0, alt_wdata = 32'h0;
    logic          alt_rdy, alt_err;
    logic [31:0]   alt_rdata;
    logic          fl_rd, fl_wr;
    logic [AW-1:0] fl_addr;
    logic [31:0]   fl_wdata;
    logic [31:0]   fl_rdata = 32'h0;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    flash_bar_decoder i_flash_bar_decoder (
        .clk(clk), .rst_n(rst_n),
        .boot_rcon(boot_rcon), .boot_mode(boot_mode), .boot_sel(boot_sel),
        .sec_flag(sec_flag), .periph_base(pbase[31:LOG2_BYTES]),
        .bar_we(bar_we), .bar_wbase(bar_wfull[31:LOG2_BYTES]), .bar_wvalid(bar_wvalid),
        .bar_rbase(bar_rbase), .bar_rvalid(bar_rvalid),
        .core_req(core_req), .core_we(core_we), .core_addr(core_a[31:2]),
        .core_wdata(core_wdata), .core_rdy(core_rdy), .core_err(core_err),
        .core_rdata(core_rdata),
        .alt_req(alt_req), .alt_we(alt_we), .alt_addr(alt_a[31:2]),
        .alt_wdata(alt_wdata), .alt_rdy(alt_rdy), .alt_err(alt_err),
        .alt_rdata(alt_rdata),
        .fl_rd(fl_rd), .fl_wr(fl_wr), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_rdata(fl_rdata)
    );

    function automatic logic [31:0] fdat(input logic [31:0] idx);
        return 32'hC3A5_0000 ^ idx;
    endfunction

    // flash model: registered read data
    always @(posedge clk) begin
        if (fl_rd) fl_rdata <= fdat({{(32-AW){1'b0}}, fl_addr});
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // results of one run
    int          c_at, m_at, rd_at, wr_at, rd_cnt;
    logic        c_e, m_e;
    logic [31:0] c_d, m_d, rd_idx, wr_idx, wr_d;

    task automatic do_reset(input logic rc, input logic [2:0] md,
                            input logic [1:0] sl, input logic sc);
        @(negedge clk);
        boot_rcon = rc; boot_mode = md; boot_sel = sl; sec_flag = sc;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_bar(input logic [31:0] v, input logic vb);
        @(negedge clk);
        bar_we = 1'b1; bar_wfull = v; bar_wvalid = vb;
        @(negedge clk);
        bar_we = 1'b0;
    endtask

    task automatic run(input bit ce, input int cs, input logic cw, input logic [31:0] ca,
                       input logic [31:0] cd,
                       input bit me, input int ms, input logic mw, input logic [31:0] ma,
                       input logic [31:0] md);
        c_at = -1; m_at = -1; rd_at = -1; wr_at = -1; rd_cnt = 0;
        c_e = 1'b0; m_e = 1'b0; c_d = 32'h0; m_d = 32'h0;
        rd_idx = 32'h0; wr_idx = 32'h0; wr_d = 32'h0;
        @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            if (core_rdy && c_at < 0) begin c_at = k; c_e = core_err; c_d = core_rdata; end
            if (alt_rdy && m_at < 0) begin m_at = k; m_e = alt_err; m_d = alt_rdata; end
            core_req = ce && (k == cs); core_we = cw; core_a = ca; core_wdata = cd;
            alt_req = me && (k == ms); alt_we = mw; alt_a = ma; alt_wdata = md;
            #1;
            if (fl_rd) begin
                rd_cnt++;
                if (rd_at < 0) begin rd_at = k; rd_idx = {{(32-AW){1'b0}}, fl_addr}; end
            end
            if (fl_wr && wr_at < 0) begin
                wr_at = k; wr_idx = {{(32-AW){1'b0}}, fl_addr}; wr_d = fl_wdata;
            end
            @(negedge clk);
        end
        core_req = 1'b0; alt_req = 1'b0;
    endtask

    task automatic t_reset_state;
        do_reset(1'b1, 3'b110, 2'b11, 1'b0);
        @(negedge clk);
        chk("R1", "valid single-chip", 32'(bar_rvalid), 32'h1);
        chk("R3", "base zero", 32'(bar_rbase), 32'h0);
        chk("R6", "idle rdy", {30'h0, core_rdy, alt_rdy}, 32'h0);
        chk("R6", "idle flash", {30'h0, fl_rd, fl_wr}, 32'h0);
    endtask

    task automatic t_boot_modes;
        do_reset(1'b1, 3'b111, 2'b00, 1'b0);
        chk("R1", "master internal", 32'(bar_rvalid), 32'h1);
        do_reset(1'b1, 3'b111, 2'b01, 1'b0);
        chk("R1", "master sel 01", 32'(bar_rvalid), 32'h0);
        do_reset(1'b0, 3'b110, 2'b00, 1'b0);
        chk("R1", "rcon low", 32'(bar_rvalid), 32'h0);
        do_reset(1'b1, 3'b101, 2'b00, 1'b0);
        chk("R1", "mode 101", 32'(bar_rvalid), 32'h0);
        do_reset(1'b0, 3'b000, 2'b11, 1'b1);
        chk("R2", "secured forces valid", 32'(bar_rvalid), 32'h1);
        chk("R2", "secured base zero", 32'(bar_rbase), 32'h0);
    endtask

    task automatic t_bar_keep;
        do_reset(1'b1, 3'b110, 2'b00, 1'b0);
        write_bar(32'h2008_0000, 1'b1);
        chk("R4", "base written", {bar_rbase, {LOG2_BYTES{1'b0}}}, 32'h2008_0000);
        chk("R4", "valid written", 32'(bar_rvalid), 32'h1);
        do_reset(1'b1, 3'b010, 2'b00, 1'b0);
        chk("R3", "base kept", {bar_rbase, {LOG2_BYTES{1'b0}}}, 32'h2008_0000);
        chk("R3", "valid cleared", 32'(bar_rvalid), 32'h0);
        run(1, 0, 1'b0, 32'h2008_0010, 32'h0, 0, 0, 1'b0, 32'h0, 32'h0);
        chk("R10", "invalid window no rdy", 32'(c_at), 32'hFFFF_FFFF);
        chk("R10", "invalid window no flash", 32'(rd_at), 32'hFFFF_FFFF);
        // write during reset ignored
        @(negedge clk);
        rst_n = 1'b0; bar_we = 1'b1; bar_wfull = 32'h3000_0000; bar_wvalid = 1'b0;
        boot_rcon = 1'b0; sec_flag = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; bar_we = 1'b0;
        chk("R4", "write in reset ignored", {bar_rbase, {LOG2_BYTES{1'b0}}}, 32'h2008_0000);
        do_reset(1'b1, 3'b110, 2'b00, 1'b0);
        chk("R3", "base zero on valid boot", 32'(bar_rbase), 32'h0);
    endtask

    task automatic t_direct;
        write_bar(32'h2008_0000, 1'b1);
        run(1, 0, 1'b0, 32'h2008_0ABC, 32'h0, 0, 0, 1'b0, 32'h0, 32'h0);
        chk("R6", "direct rdy cycle", 32'(c_at), 32'd1);
        chk("R6", "direct flash cycle", 32'(rd_at), 32'd0);
        chk("R5", "direct index", rd_idx, 32'h2AF);
        chk("R6", "direct data", c_d, fdat(32'h2AF));
        run(1, 0, 1'b0, 32'h200F_FFFC, 32'h0, 0, 0, 1'b0, 32'h0, 32'h0);
        chk("R5", "top of window", c_d, fdat(32'h1FFFF));
        run(1, 0, 1'b0, 32'h2010_0000, 32'h0, 0, 0, 1'b0, 32'h0, 32'h0);
        chk("R10", "outside window no rdy", 32'(c_at), 32'hFFFF_FFFF);
        chk("R10", "outside window no flash", 32'(rd_cnt), 32'h0);
    endtask

    task automatic t_backdoor;
        run(1, 0, 1'b0, 32'h4400_0100, 32'h0, 0, 0, 1'b0, 32'h0, 32'h0);
        chk("R7", "core bd rdy cycle", 32'(c_at), 32'd3);
        chk("R7", "core bd data", c_d, fdat(32'h40));
        run(0, 0, 1'b0, 32'h0, 32'h0, 1, 0, 1'b0, 32'h4407_FFFC, 32'h0);
        chk("R7", "alt bd rdy cycle", 32'(m_at), 32'd3);
        chk("R7", "alt bd data", m_d, fdat(32'h1FFFF));
        run(0, 0, 1'b0, 32'h0, 32'h0, 1, 0, 1'b1, 32'h4400_0040, 32'hDEAD_BEEF);
        chk("R8", "alt wr cycle", 32'(wr_at), 32'd2);
        chk("R8", "alt wr index", wr_idx, 32'h10);
        chk("R8", "alt wr data", wr_d, 32'hDEAD_BEEF);
        chk("R8", "alt wr rdy", 32'(m_at), 32'd3);
        run(1, 0, 1'b1, 32'h4400_0008, 32'h1234_5678, 0, 0, 1'b0, 32'h0, 32'h0);
        chk("R8", "core wr cycle", 32'(wr_at), 32'd2);
        chk("R8", "core wr data", wr_d, 32'h1234_5678);
        chk("R8", "core wr rdy no err", {c_at[30:0], c_e}, {31'd3, 1'b0});
        pbase = 32'h5000_0000;
        run(0, 0, 1'b0, 32'h0, 32'h0, 1, 0, 1'b0, 32'h5400_0008, 32'h0);
        chk("R7", "moved bd rdy", 32'(m_at), 32'd3);
        run(0, 0, 1'b0, 32'h0, 32'h0, 1, 0, 1'b0, 32'h4400_0008, 32'h0);
        chk("R7", "old bd ignored", 32'(m_at), 32'hFFFF_FFFF);
        pbase = 32'h4000_0000;
    endtask

    task automatic t_errors;
        run(0, 0, 1'b0, 32'h0, 32'h0, 1, 0, 1'b0, 32'h2008_0000, 32'h0);
        chk("R9", "alt base err", {m_at[30:0], m_e}, {31'd1, 1'b1});
        chk("R9", "alt base no flash", 32'(rd_cnt), 32'h0);
        run(1, 0, 1'b1, 32'h2008_0004, 32'h5555_5555, 0, 0, 1'b0, 32'h0, 32'h0);
        chk("R9", "core base write err", {c_at[30:0], c_e}, {31'd1, 1'b1});
        chk("R9", "core base write no flash", 32'(wr_at), 32'hFFFF_FFFF);
    endtask

    task automatic t_collide;
        run(1, 2, 1'b0, 32'h2008_0020, 32'h0, 1, 0, 1'b0, 32'h4400_0030, 32'h0);
        chk("R11", "bd keeps port", 32'(m_at), 32'd3);
        chk("R11", "bd data", m_d, fdat(32'hC));
        chk("R11", "direct deferred", 32'(c_at), 32'd4);
        chk("R11", "deferred data", c_d, fdat(32'h8));
        run(1, 0, 1'b0, 32'h4400_0050, 32'h0, 1, 0, 1'b0, 32'h4400_0060, 32'h0);
        chk("R12", "alt enters first", 32'(m_at), 32'd3);
        chk("R12", "core one later", 32'(c_at), 32'd4);
        chk("R12", "core data", c_d, fdat(32'h14));
    endtask

    task automatic t_overlap;
        write_bar(32'h4400_0000, 1'b1);
        run(1, 0, 1'b0, 32'h4400_0020, 32'h0, 0, 0, 1'b0, 32'h0, 32'h0);
        chk("R13", "both windows direct", 32'(c_at), 32'd1);
        chk("R13", "both windows data", c_d, fdat(32'h8));
        run(1, 0, 1'b1, 32'h4400_0024, 32'hA5A5_0001, 0, 0, 1'b0, 32'h0, 32'h0);
        chk("R13", "overlap write via bd", 32'(wr_at), 32'd2);
        chk("R13", "overlap write no err", 32'(c_e), 32'h0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_boot_modes();
        t_bar_keep();
        t_direct();
        t_backdoor();
        t_errors();
        t_collide();
        t_overlap();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule